// File: doc/BRIEF.md
# Locality-Arbitrated Command FIFO Interface

This block is the target side of a small byte-addressed register port in front of a security coprocessor. A host first claims the single locality through an access register. It then streams a command byte by byte into a data FIFO and starts execution by writing a flag to the status register. Finally it reads the response back through the same FIFO address. Flag writes to the status register drive the whole handshake. Writing the ready flag aborts the current command and re-arms the block. Writing the go flag starts execution. Writing the retry flag rewinds the response. A 16-bit burst count beside the flags tells the host how many bytes it may move next.

Command execution is modelled by a stub engine. After a fixed number of cycles it produces a 10-byte response. The response has a 6-byte header and then echoes command bytes 6 to 9. The FIFO holds 64 bytes.

The controller is a five-state machine:

| State | Meaning |
|---|---|
| READY | Idle and armed. |
| RECEIVE | Command entry in progress. |
| FULL | Command complete. |
| EXECUTE | Stub engine running. |
| RESPOND | Response readable. |

Its transitions:

- READY goes to RECEIVE on an accepted FIFO write. It goes straight to FULL if that write is already the last byte.
- RECEIVE goes to FULL on the last byte.
- FULL goes to EXECUTE on go.
- EXECUTE goes to RESPOND when the engine finishes.
- A ready-flag write moves any state back to READY.

Top module: `cmd_fifo_port`

## Requirements
- R1: The access register sits at byte offset 0x0. Bit 7 reads as 1 (valid) and bit 5 reads as 1 while the locality is held. Writing byte 0 with bit 0 set and bit 5 clear grants the locality when it is free, so the access register then reads 0xA0.
- R2: Writing the access register with bit 5 set releases the locality, so it reads 0x80 again.
- R3: A FIFO write (offset 0x8, byte 0) is ignored while the locality is not held, and also in FULL, EXECUTE and RESPOND. The status word is unchanged afterwards.
- R4: The status register sits at offset 0x4, with flags in byte 0: bit 7 valid, bit 6 ready, bit 5 go, bit 4 available, bit 3 expect, bit 1 retry. Command bytes 2-5 give the total length, big-endian. Expect (flags 0x88) stays set until the byte count reaches that length, counting at least 6 bytes, or until the FIFO is full. After that byte the flags read 0x80.
- R5: The burst count is in status bits 23:8. It reads 64 in READY, 64 minus the bytes written in RECEIVE, and 0 in FULL and EXECUTE.
- R6: A status read with byte strobes 0110 returns only the burst count, with the other lanes zero. Such a read leaves the flags unchanged.
- R7: Writing go (0x20) in FULL starts execution, and valid reads 0 during it. After EXEC_CYCLES cycles the flags read 0x90 (available and valid).
- R8: Each FIFO read in RESPOND returns the next response byte. The response is 00 C4 00 00 00 0A, then command bytes 6-9, with 00 for any byte the command did not have. The burst count gives the bytes left. After the last byte the flags read 0x80, the burst reads 0, and further reads return 0.
- R9: Writing retry (0x02) in RESPOND restarts delivery from response byte 0.
- R10: Writing ready (0x40) while holding the locality returns any state to READY. Status then reads flags 0xC0 with burst 64.
- R11: The ID register at offset 0xC reads DEVICE_ID.
- R12: After reset the access register reads 0x80 and status reads flags 0xC0 with burst 64.
- R13: A go write outside FULL is ignored.

Read data appears on `bus_rdata` in the cycle after the read strobe, and byte lanes that are not enabled read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
Directed sequences cover the edges: a command whose header length exceeds the FIFO, writes without the locality and in the wrong state, a premature go, and burst-only reads in the middle of entry. These separate a length-driven completion from a capacity-driven one, and a gated write from a dropped one. Seeded random commands of 6 to 40 bytes follow. Some are aborted partway and some have their response rewound at a random point. These separate correct pointer and counter restarts from stale state left by an earlier transaction. Every response byte is compared with a value the bench computes from the command it sent.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
    typedef enum logic [2:0] {
        ST_READY,
        ST_RECV,
        ST_FULL,
        ST_EXEC,
        ST_RESP
    } cfi_state_e;

    localparam logic [1:0] SEL_ACCESS = 2'd0;
    localparam logic [1:0] SEL_STATUS = 2'd1;
    localparam logic [1:0] SEL_FIFO   = 2'd2;
    localparam logic [1:0] SEL_ID     = 2'd3;

    localparam int F_VALID  = 7;
    localparam int F_READY  = 6;
    localparam int F_GO     = 5;
    localparam int F_AVAIL  = 4;
    localparam int F_EXPECT = 3;
    localparam int F_RETRY  = 1;

    localparam int A_VALID  = 7;
    localparam int A_ACTIVE = 5;
    localparam int A_REQ    = 0;

    localparam int HDR_LEN  = 6;
    localparam int RESP_LEN = 10;
    localparam int PW       = $clog2(RESP_LEN + 1);
    localparam logic [7:0] RESP_TAG_LO = 8'hC4;
endpackage

// File: rtl/cfi_locality.sv
module cfi_locality
    import cfi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_wr,
    input  logic [7:0] acc_byte,
    output logic       held
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (acc_wr) begin
            if (acc_byte[A_ACTIVE]) begin
                held <= 1'b0;
            end else if (acc_byte[A_REQ]) begin
                held <= 1'b1;
            end
        end
    end

    // R1
    a_r1_grant_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !held && acc_byte[A_REQ] && !acc_byte[A_ACTIVE]) |=> held);
    // R2
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_byte[A_ACTIVE]) |=> !held);
endmodule

// File: rtl/cfi_cmd_store.sv
module cfi_cmd_store
    import cfi_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [7:0]    push_byte,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_byte,
    output logic [CW-1:0] count,
    output logic          last_push
);
    logic [7:0]    mem [DEPTH];
    logic [31:0]   len_q;
    logic [31:0]   len_nx;
    logic [CW-1:0] cnt_nx;

    assign cnt_nx = count + CW'(1);

    always_comb begin
        len_nx = len_q;
        if (count >= CW'(2) && count <= CW'(5)) begin
            len_nx = {len_q[23:0], push_byte};
        end
    end

    assign last_push = push &&
        ((cnt_nx >= CW'(HDR_LEN) && 32'(cnt_nx) >= len_nx) || cnt_nx == CW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            len_q <= '0;
        end else if (clear) begin
            count <= '0;
            len_q <= '0;
        end else if (push) begin
            count <= cnt_nx;
            len_q <= len_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[count[AW-1:0]] <= push_byte;
        end
    end

    assign rd_byte = mem[rd_idx];

    // R5
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/cfi_stub_engine.sv
module cfi_stub_engine
    import cfi_pkg::*;
#(
    parameter int EXEC_CYCLES = 8,
    parameter int CW = 7,
    localparam int TW = $clog2(EXEC_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [PW-1:0] rsp_idx,
    input  logic [7:0]    cmd_byte,
    input  logic [CW-1:0] cmd_count,
    output logic          done,
    output logic [7:0]    rsp_byte
);
    logic          busy;
    logic [TW-1:0] tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            tick <= '0;
        end else if (abort) begin
            busy <= 1'b0;
            tick <= '0;
        end else if (start) begin
            busy <= 1'b1;
            tick <= '0;
        end else if (busy) begin
            if (tick == TW'(EXEC_CYCLES - 1)) begin
                busy <= 1'b0;
            end else begin
                tick <= tick + TW'(1);
            end
        end
    end

    assign done = busy && (tick == TW'(EXEC_CYCLES - 1));

    always_comb begin
        rsp_byte = 8'h00;
        if (rsp_idx == PW'(1)) begin
            rsp_byte = RESP_TAG_LO;
        end else if (rsp_idx == PW'(5)) begin
            rsp_byte = 8'(RESP_LEN);
        end else if (rsp_idx >= PW'(HDR_LEN) && rsp_idx < PW'(RESP_LEN)
                     && CW'(rsp_idx) < cmd_count) begin
            rsp_byte = cmd_byte;
        end
    end

    // R7
    a_r7_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy);
endmodule

// File: rtl/cmd_fifo_port.sv
module cmd_fifo_port
    import cfi_pkg::*;
#(
    parameter int          DEPTH       = 64,
    parameter int          EXEC_CYCLES = 8,
    parameter logic [31:0] DEVICE_ID   = 32'h5A17_C0DE,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    cfi_state_e    state, state_nx;
    logic          held;
    logic [CW-1:0] cmd_count;
    logic          last_push;
    logic [7:0]    cmd_byte;
    logic [7:0]    rsp_byte;
    logic          eng_done;
    logic [PW-1:0] rd_ptr;
    logic [7:0]    flags;
    logic [15:0]   burst;
    logic [31:0]   rd_word;
    logic [1:0]    sel;
    logic [7:0]    wbyte;
    logic          acc_wr, sts_wr, fifo_wr, fifo_rd;
    logic          abort, go, retry;
    logic          unused_bits;

    assign sel         = bus_addr[3:2];
    assign wbyte       = bus_wdata[7:0];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:8]};

    assign acc_wr  = bus_wr && sel == SEL_ACCESS && bus_be[0];
    assign sts_wr  = bus_wr && sel == SEL_STATUS && bus_be[0] && held;
    assign fifo_wr = bus_wr && sel == SEL_FIFO && bus_be[0] && held
                     && (state == ST_READY || state == ST_RECV);
    assign fifo_rd = bus_rd && sel == SEL_FIFO && bus_be[0] && held
                     && state == ST_RESP && rd_ptr < PW'(RESP_LEN);
    assign abort   = sts_wr && wbyte[F_READY];
    assign go      = sts_wr && !wbyte[F_READY] && wbyte[F_GO] && state == ST_FULL;
    assign retry   = sts_wr && !wbyte[F_READY] && wbyte[F_RETRY] && state == ST_RESP;

    cfi_locality u_loc (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_wr   (acc_wr),
        .acc_byte (wbyte),
        .held     (held)
    );

    cfi_cmd_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (abort),
        .push      (fifo_wr),
        .push_byte (wbyte),
        .rd_idx    (AW'(rd_ptr)),
        .rd_byte   (cmd_byte),
        .count     (cmd_count),
        .last_push (last_push)
    );

    cfi_stub_engine #(.EXEC_CYCLES(EXEC_CYCLES), .CW(CW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (go),
        .abort     (abort),
        .rsp_idx   (rd_ptr),
        .cmd_byte  (cmd_byte),
        .cmd_count (cmd_count),
        .done      (eng_done),
        .rsp_byte  (rsp_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (abort) begin
            state_nx = ST_READY;
        end else begin
            unique case (state)
                ST_READY: if (fifo_wr) state_nx = last_push ? ST_FULL : ST_RECV;
                ST_RECV:  if (fifo_wr && last_push) state_nx = ST_FULL;
                ST_FULL:  if (go) state_nx = ST_EXEC;
                ST_EXEC:  if (eng_done) state_nx = ST_RESP;
                ST_RESP:  state_nx = ST_RESP;
                default:  state_nx = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (abort || eng_done || retry) begin
            rd_ptr <= '0;
        end else if (fifo_rd) begin
            rd_ptr <= rd_ptr + PW'(1);
        end
    end

    always_comb begin
        flags           = 8'h00;
        flags[F_VALID]  = (state != ST_EXEC);
        flags[F_READY]  = (state == ST_READY);
        flags[F_EXPECT] = (state == ST_RECV);
        flags[F_AVAIL]  = (state == ST_RESP) && (rd_ptr < PW'(RESP_LEN));
        unique case (state)
            ST_READY: burst = 16'(DEPTH);
            ST_RECV:  burst = 16'(DEPTH) - 16'(cmd_count);
            ST_RESP:  burst = 16'(RESP_LEN) - 16'(rd_ptr);
            default:  burst = 16'h0000;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_ACCESS: rd_word = {24'h0, 1'b1, 1'b0, held, 5'b0};
            SEL_STATUS: rd_word = {8'h00, burst, flags};
            SEL_FIFO:   rd_word = fifo_rd ? {24'h0, rsp_byte} : 32'h0;
            default:    rd_word = DEVICE_ID;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_word & {{8{bus_be[3]}}, {8{bus_be[2]}},
                                    {8{bus_be[1]}}, {8{bus_be[0]}}};
        end
    end

    // R3
    a_r3_locked_out: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_FIFO && !held) |=> $stable(cmd_count));
    // R7
    a_r7_go_executes: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> state == ST_EXEC);
    // R8
    a_r8_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= PW'(RESP_LEN));
    // R9
    a_r9_retry_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        retry |=> rd_ptr == '0);
    // R10
    a_r10_abort_ready: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == ST_READY && cmd_count == '0));
endmodule

// File: tb/cmd_fifo_port_tb.sv
`timescale 1ns/1ps
module cmd_fifo_port_tb;
    localparam int DEPTH = 64;
    localparam int EXEC_CYCLES = 8;
    localparam logic [31:0] DEVICE_ID = 32'h5A17_C0DE;
    localparam logic [3:0] A_ACC = 4'h0, A_STS = 4'h4, A_FIFO = 4'h8, A_ID = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0, bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int tests = 0, fails = 0;
    logic [7:0] cmd [DEPTH];

    always #4 clk = ~clk;

    cmd_fifo_port #(.DEPTH(DEPTH), .EXEC_CYCLES(EXEC_CYCLES), .DEVICE_ID(DEVICE_ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] sts(input int burst, input logic [7:0] fl);
        return {8'h00, 16'(burst), fl};
    endfunction

    function automatic logic [7:0] exp_rsp(input int idx, input int ncmd);
        if (idx == 1) return 8'hC4;
        if (idx == 5) return 8'd10;
        if (idx >= 6 && idx < 10 && idx < ncmd) return cmd[idx];
        return 8'h00;
    endfunction

    function automatic int hdr_len();
        return {cmd[2], cmd[3], cmd[4], cmd[5]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [3:0] be, output logic [31:0] d);
        bus_addr = a; bus_be = be; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // writes bytes [from, to) and checks status after the last one
    task automatic send_bytes(input int from, input int upto, input bit each);
        logic [31:0] r;
        for (int k = from; k < upto; k++) begin
            bus_write(A_FIFO, 4'b0001, {24'h0, cmd[k]});
            if (each || k == upto - 1) begin
                bus_read(A_STS, 4'hF, r);
                if ((k + 1 >= 6 && k + 1 >= hdr_len()) || k + 1 == DEPTH)
                    check("R4 status after final byte", r, sts(0, 8'h80));
                else
                    check("R4/R5 expect and burst during entry", r, sts(DEPTH - k - 1, 8'h88));
            end
        end
    endtask

    task automatic wait_resp();
        logic [31:0] r;
        int n = 0;
        bus_read(A_STS, 4'hF, r);
        check("R7 valid low while executing", {24'h0, r[7:0]}, 32'h0);
        while (r[7:0] != 8'h90 && n < EXEC_CYCLES + 4) begin
            bus_read(A_STS, 4'hF, r);
            n++;
        end
        check("R7 response ready after go", r, sts(10, 8'h90));
    endtask

    task automatic read_rsp(input int from, input int upto, input int ncmd);
        logic [31:0] r;
        for (int i = from; i < upto; i++) begin
            bus_read(A_FIFO, 4'b0001, r);
            check("R8 response byte", r, {24'h0, exp_rsp(i, ncmd)});
        end
    endtask

    task automatic fill_cmd(input int n, input int lenfield);
        cmd[0] = 8'h00; cmd[1] = 8'hC1;
        {cmd[2], cmd[3], cmd[4], cmd[5]} = 32'(lenfield);
        for (int i = 6; i < DEPTH; i++) cmd[i] = 8'($urandom);
        if (n < 6) cmd[0] = 8'h00;
    endtask

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        bus_read(A_ACC, 4'hF, r);  check("R12 access after reset", r, 32'h80);
        bus_read(A_STS, 4'hF, r);  check("R12 status after reset", r, sts(64, 8'hC0));
        bus_read(A_ID, 4'hF, r);   check("R11 id register", r, DEVICE_ID);

        bus_write(A_FIFO, 4'b0001, 32'h11);
        bus_read(A_STS, 4'hF, r);  check("R3 write without locality ignored", r, sts(64, 8'hC0));

        bus_write(A_ACC, 4'b0001, 32'h01);
        bus_read(A_ACC, 4'hF, r);  check("R1 locality granted", r, 32'hA0);

        // directed command of 12 bytes
        fill_cmd(12, 12);
        send_bytes(0, 4, 1'b1);
        bus_read(A_STS, 4'b0110, r); check("R6 burst-only read", r, {8'h0, 16'd60, 8'h00});
        bus_read(A_STS, 4'hF, r);    check("R6 flags untouched by burst read", r, sts(60, 8'h88));
        bus_write(A_STS, 4'b0001, 32'h20);
        bus_read(A_STS, 4'hF, r);    check("R13 early go ignored", r, sts(60, 8'h88));
        send_bytes(4, 12, 1'b1);
        bus_write(A_FIFO, 4'b0001, 32'h77);
        bus_read(A_STS, 4'hF, r);    check("R3 write in FULL ignored", r, sts(0, 8'h80));
        bus_write(A_STS, 4'b0001, 32'h20);
        wait_resp();
        read_rsp(0, 4, 12);
        bus_read(A_STS, 4'hF, r);    check("R8 burst counts remaining", r, sts(6, 8'h90));
        bus_write(A_STS, 4'b0001, 32'h02);
        bus_read(A_STS, 4'hF, r);    check("R9 retry rewinds", r, sts(10, 8'h90));
        read_rsp(0, 10, 12);
        bus_read(A_STS, 4'hF, r);    check("R8 drained status", r, sts(0, 8'h80));
        bus_read(A_FIFO, 4'b0001, r); check("R8 read past end", r, 32'h0);
        bus_write(A_STS, 4'b0001, 32'h40);
        bus_read(A_STS, 4'hF, r);    check("R10 abort to ready", r, sts(64, 8'hC0));

        // header length larger than the FIFO: completes on capacity
        fill_cmd(DEPTH, 200);
        send_bytes(0, DEPTH - 1, 1'b0);
        send_bytes(DEPTH - 1, DEPTH, 1'b0);
        bus_write(A_STS, 4'b0001, 32'h20);
        wait_resp();
        read_rsp(0, 10, DEPTH);
        bus_write(A_STS, 4'b0001, 32'h40);

        // seeded random commands
        for (int it = 0; it < 24; it++) begin
            int n = 6 + int'($urandom % 35);
            int cut = ($urandom % 4 == 0) ? 1 + int'($urandom % 5) : 0;
            fill_cmd(n, n);
            if (cut != 0) begin
                send_bytes(0, cut, 1'b0);
                bus_write(A_STS, 4'b0001, 32'h40);
                bus_read(A_STS, 4'hF, r); check("R10 abort during entry", r, sts(64, 8'hC0));
            end else begin
                send_bytes(0, n, 1'b0);
                bus_write(A_STS, 4'b0001, 32'h20);
                wait_resp();
                if ($urandom % 2 == 1) begin
                    int k = 1 + int'($urandom % 9);
                    read_rsp(0, k, n);
                    bus_write(A_STS, 4'b0001, 32'h02);
                end
                read_rsp(0, 10, n);
                bus_write(A_STS, 4'b0001, 32'h40);
                bus_read(A_STS, 4'hF, r); check("R10 abort after response", r, sts(64, 8'hC0));
            end
        end

        bus_write(A_ACC, 4'b0001, 32'h20);
        bus_read(A_ACC, 4'hF, r);  check("R2 locality released", r, 32'h80);
        bus_write(A_FIFO, 4'b0001, 32'h33);
        bus_read(A_STS, 4'hF, r);  check("R3 write after release ignored", r, sts(64, 8'hC0));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule